// File: doc/BRIEF.md
# Fractional Baud Tick Generator

This block turns a system clock into a one-cycle enable pulse that marks sixteen sub-intervals of every UART bit. Three stages produce it. A prescaler picks one of four fixed ratios from a two-bit code. A 16-bit integer divisor, given as a high byte and a low byte, counts prescaled pulses. A fractional stage then lengthens some divisor periods, so that the average pulse spacing is a non-integer multiple of the prescaled period.

The fractional stage keeps a running accumulator. Each emitted tick adds the add value to it. When the sum reaches the multiply value, the multiply value is taken off and the next tick interval is doubled. Over time the tick rate becomes PCLK / (divisor × (1 + add/mul)), and the baud rate is one sixteenth of that. The receiver and transmitter use the pulse as a clock enable; it is never a derived clock.

Top module: `baud_tick_gen`

## Requirements
- R1: The prescale code sets the prescaled period: code 2'b00 gives 4 system cycles, 2'b01 gives 1, 2'b10 gives 2 and 2'b11 gives 8. The code is held in a register that takes 2'b00 while reset is asserted.
- R2: With the fractional stage off, successive ticks are exactly ratio × D system cycles apart, where D = 256 × high byte + low byte.
- R3: A divisor of zero behaves exactly like a divisor of one, so ticks continue at the prescaled period.
- R4: With the fractional stage on, an accumulator starting at zero adds the add value at every tick. When the result is at least the multiply value, the multiply value is subtracted and the interval to the following tick is 2 × ratio × D; otherwise that interval is ratio × D.
- R5: The fractional stage is off when the add value is zero or when the add value is not below the multiply value (including a multiply value of zero); every interval is then ratio × D.
- R6: The tick is a single system-cycle enable. It is low while reset is asserted and in the first cycle after a reset edge.
- R7: Reset clears the prescaler, the divisor counter, the pending stretch and the accumulator, so the stretch pattern of R4 restarts from an accumulator of zero.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| presc_sel_i | input | 2 | Prescale code (R1 encoding) |
| div_hi_i | input | 8 | Divisor high byte |
| div_lo_i | input | 8 | Divisor low byte |
| frac_add_i | input | 4 | Fractional add value |
| frac_mul_i | input | 4 | Fractional multiply value |
| tick_o | output | 1 | One-cycle 16x-oversampling enable |

## Verification
All internal state shows at the port only as the spacing between ticks, so the checks compare every gap against a model of the accumulator. A prescaler or divisor counter that wraps at the wrong value moves the very next tick. An accumulator that is off by one moves a doubled interval within at most one multiply-value cycle of ticks. A stretch flag that is not cleared by reset shows as a wrong first gap after reset.

// File: rtl/brg_pkg.sv
package brg_pkg;

    typedef enum logic [1:0] {
        PS_DIV4 = 2'b00,
        PS_DIV1 = 2'b01,
        PS_DIV2 = 2'b10,
        PS_DIV8 = 2'b11
    } presc_e;

    localparam int PRE_CNT_W = 3;

    // Last count value of the prescaler for each ratio code.
    function automatic logic [PRE_CNT_W-1:0] presc_last(presc_e code);
        logic [PRE_CNT_W-1:0] r;
        case (code)
            PS_DIV1: r = 3'd0;
            PS_DIV2: r = 3'd1;
            PS_DIV8: r = 3'd7;
            default: r = 3'd3;
        endcase
        return r;
    endfunction

    typedef struct packed {
        logic pend;   // divisor period ended on this prescaled pulse
        logic fire;   // that end emits a tick
    } div_evt_t;

endpackage

// File: rtl/brg_prescaler.sv
module brg_prescaler
    import brg_pkg::*;
(
    input  logic       clk,
    input  logic       rst,
    input  logic [1:0] sel_i,
    output logic       pclk_en_o
);

    presc_e                 sel_q;
    logic [PRE_CNT_W-1:0]   cnt_q;
    logic [PRE_CNT_W-1:0]   cnt_last;

    assign cnt_last  = presc_last(sel_q);
    assign pclk_en_o = (cnt_q >= cnt_last);

    always_ff @(posedge clk) begin
        if (rst) begin
            sel_q <= PS_DIV4;
            cnt_q <= '0;
        end else begin
            sel_q <= presc_e'(sel_i);
            cnt_q <= pclk_en_o ? '0 : cnt_q + 1'b1;
        end
    end

    // R1
    sel_reset_chk: assert property (@(posedge clk) rst |=> (sel_q == PS_DIV4));

    // R1
    presc_gap_chk: assert property (@(posedge clk) disable iff (rst)
        (pclk_en_o && sel_q != PS_DIV1 && $stable(sel_q)) |=> (!pclk_en_o || sel_q == PS_DIV1));

endmodule

// File: rtl/brg_frac_acc.sv
module brg_frac_acc #(
    parameter int FRAC_W = 4
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              fire_i,
    input  logic [FRAC_W-1:0] add_i,
    input  logic [FRAC_W-1:0] mul_i,
    output logic              stretch_o
);

    localparam int SUM_W = FRAC_W + 1;

    logic [FRAC_W-1:0] acc_q;
    logic              stretch_q;
    logic              frac_en;
    logic [SUM_W-1:0]  sum;
    logic              wrap;
    logic [SUM_W-1:0]  sum_less;

    assign frac_en   = (add_i != '0) && (add_i < mul_i);
    assign sum       = {1'b0, acc_q} + {1'b0, add_i};
    assign wrap      = (sum >= {1'b0, mul_i});
    assign sum_less  = sum - {1'b0, mul_i};
    assign stretch_o = stretch_q;

    always_ff @(posedge clk) begin
        if (rst || !frac_en) begin
            acc_q     <= '0;
            stretch_q <= 1'b0;
        end else if (fire_i) begin
            if (wrap) begin
                acc_q     <= sum_less[FRAC_W-1:0];
                stretch_q <= 1'b1;
            end else begin
                acc_q     <= sum[FRAC_W-1:0];
                stretch_q <= 1'b0;
            end
        end
    end

    // R5
    frac_off_chk: assert property (@(posedge clk) disable iff (rst)
        !frac_en |=> !stretch_q);

    // R4
    frac_hold_chk: assert property (@(posedge clk) disable iff (rst)
        (frac_en && !fire_i) |=> $stable(stretch_q));

    // R7
    frac_rst_chk: assert property (@(posedge clk) rst |=> (!stretch_q && acc_q == '0));

endmodule

// File: rtl/brg_int_div.sv
module brg_int_div
    import brg_pkg::*;
#(
    parameter int BYTE_W = 8
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              pclk_en_i,
    input  logic [BYTE_W-1:0] div_hi_i,
    input  logic [BYTE_W-1:0] div_lo_i,
    input  logic              stretch_i,
    output logic              fire_o,
    output logic              tick_o
);

    localparam int DIV_W = 2 * BYTE_W;

    logic [DIV_W-1:0] div_raw;
    logic [DIV_W-1:0] div_last;
    logic [DIV_W-1:0] cnt_q;
    logic             ext_q;
    logic             tick_q;
    div_evt_t         evt;

    assign div_raw  = {div_hi_i, div_lo_i};
    assign div_last = (div_raw == '0) ? '0 : div_raw - 1'b1;

    always_comb begin
        evt.pend = pclk_en_i && (cnt_q >= div_last);
        evt.fire = evt.pend && !(stretch_i && !ext_q);
    end

    assign fire_o = evt.fire;
    assign tick_o = tick_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            cnt_q  <= '0;
            ext_q  <= 1'b0;
            tick_q <= 1'b0;
        end else begin
            tick_q <= evt.fire;
            if (pclk_en_i) begin
                cnt_q <= evt.pend ? '0 : cnt_q + 1'b1;
                if (evt.pend) begin
                    ext_q <= stretch_i && !ext_q;
                end
            end
        end
    end

    // R6
    tick_rst_chk: assert property (@(posedge clk) rst |=> !tick_q);

    // R4
    tick_ext_chk: assert property (@(posedge clk) disable iff (rst)
        tick_q |-> !ext_q);

    // R4
    ext_src_chk: assert property (@(posedge clk) disable iff (rst)
        $rose(ext_q) |-> $past(stretch_i));

endmodule

// File: rtl/baud_tick_gen.sv
module baud_tick_gen #(
    parameter int BYTE_W = 8,
    parameter int FRAC_W = 4
) (
    input  logic              clk,
    input  logic              rst,
    input  logic [1:0]        presc_sel_i,
    input  logic [BYTE_W-1:0] div_hi_i,
    input  logic [BYTE_W-1:0] div_lo_i,
    input  logic [FRAC_W-1:0] frac_add_i,
    input  logic [FRAC_W-1:0] frac_mul_i,
    output logic              tick_o
);

    logic pclk_en;
    logic fire;
    logic stretch;

    brg_prescaler u_pre (
        .clk       (clk),
        .rst       (rst),
        .sel_i     (presc_sel_i),
        .pclk_en_o (pclk_en)
    );

    brg_int_div #(.BYTE_W(BYTE_W)) u_div (
        .clk       (clk),
        .rst       (rst),
        .pclk_en_i (pclk_en),
        .div_hi_i  (div_hi_i),
        .div_lo_i  (div_lo_i),
        .stretch_i (stretch),
        .fire_o    (fire),
        .tick_o    (tick_o)
    );

    brg_frac_acc #(.FRAC_W(FRAC_W)) u_frac (
        .clk       (clk),
        .rst       (rst),
        .fire_i    (fire),
        .add_i     (frac_add_i),
        .mul_i     (frac_mul_i),
        .stretch_o (stretch)
    );

    // R2
    tick_src_chk: assert property (@(posedge clk) disable iff (rst)
        tick_o |-> $past(pclk_en));

endmodule

// File: tb/baud_tick_gen_tb.sv
module baud_tick_gen_tb;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic [1:0] presc_sel = 2'b00;
    logic [7:0] div_hi = 8'd0;
    logic [7:0] div_lo = 8'd1;
    logic [3:0] frac_add = 4'd0;
    logic [3:0] frac_mul = 4'd1;
    logic       tick;

    int total = 0;
    int bad = 0;
    int exp_q[$];
    string cur_tag = "R2";

    always #4 clk = ~clk;

    baud_tick_gen u_dut (
        .clk         (clk),
        .rst         (rst),
        .presc_sel_i (presc_sel),
        .div_hi_i    (div_hi),
        .div_lo_i    (div_lo),
        .frac_add_i  (frac_add),
        .frac_mul_i  (frac_mul),
        .tick_o      (tick)
    );

    // Monitor: measures tick spacing and compares with the scoreboard.
    int  cyc = 0;
    int  last_cyc = 0;
    bit  have_last = 0;
    always @(negedge clk) begin
        cyc++;
        if (rst) begin
            have_last = 0;
        end else if (tick) begin
            if (have_last && exp_q.size() > 0) begin
                int e;
                e = exp_q.pop_front();
                total++;
                if (cyc - last_cyc != e) begin
                    bad++;
                    $display("FAIL %s: tick interval actual=%0d expected=%0d", cur_tag, cyc - last_cyc, e);
                end
            end
            last_cyc  = cyc;
            have_last = 1;
        end
    end

    function automatic int ratio_of(logic [1:0] s);
        case (s)
            2'b01:   return 1;
            2'b10:   return 2;
            2'b11:   return 8;
            default: return 4;
        endcase
    endfunction

    // Driver: applies a setting, resets, pushes expected gaps, waits for drain.
    task automatic run_case(string tag, logic [1:0] s, logic [7:0] hi, logic [7:0] lo,
                            logic [3:0] ad, logic [3:0] mu, int n);
        int base;
        int d;
        int acc;
        bit en;
        @(posedge clk); #1;
        rst = 1'b1;
        presc_sel = s; div_hi = hi; div_lo = lo; frac_add = ad; frac_mul = mu;
        @(posedge clk); #1;
        @(posedge clk); #1;
        total++;
        if (tick !== 1'b0) begin
            bad++;
            $display("FAIL R6: tick during reset actual=%0b expected=0", tick);
        end
        cur_tag = tag;
        d = int'(hi) * 256 + int'(lo);
        if (d == 0) d = 1;
        base = ratio_of(s) * d;
        en = (ad != 0) && (ad < mu);
        acc = 0;
        for (int i = 0; i < n; i++) begin
            bit st;
            st = 0;
            if (en) begin
                acc += int'(ad);
                if (acc >= int'(mu)) begin
                    acc -= int'(mu);
                    st = 1;
                end
            end
            exp_q.push_back(st ? 2 * base : base);
        end
        rst = 1'b0;
        @(negedge clk);
        total++;
        if (tick !== 1'b0) begin
            bad++;
            $display("FAIL R6: tick right after reset actual=%0b expected=0", tick);
        end
        while (exp_q.size() != 0) @(negedge clk);
    endtask

    initial begin
        repeat (3) @(posedge clk);
        // R2: ratio 4, divisor 3 -> 12
        run_case("R2", 2'b00, 8'd0, 8'd3, 4'd0, 4'd1, 6);
        // R1: each prescale code with divisor 5
        run_case("R1", 2'b01, 8'd0, 8'd5, 4'd0, 4'd1, 5);
        run_case("R1", 2'b10, 8'd0, 8'd5, 4'd0, 4'd1, 5);
        run_case("R1", 2'b11, 8'd0, 8'd5, 4'd0, 4'd1, 4);
        // R2: high byte weight, 2 * 258
        run_case("R2", 2'b10, 8'd1, 8'd2, 4'd0, 4'd1, 3);
        // R3: zero divisor
        run_case("R3", 2'b11, 8'd0, 8'd0, 4'd0, 4'd1, 5);
        run_case("R3", 2'b01, 8'd0, 8'd0, 4'd0, 4'd1, 8);
        // R4: fractional stretch patterns
        run_case("R4", 2'b01, 8'd0, 8'd5, 4'd1, 4'd3, 9);
        run_case("R4", 2'b00, 8'd0, 8'd2, 4'd3, 4'd4, 8);
        run_case("R4", 2'b01, 8'd0, 8'd1, 4'd7, 4'd15, 12);
        // R5: fractional stage off
        run_case("R5", 2'b01, 8'd0, 8'd4, 4'd5, 4'd3, 5);
        run_case("R5", 2'b01, 8'd0, 8'd4, 4'd2, 4'd0, 5);
        run_case("R5", 2'b01, 8'd0, 8'd4, 4'd0, 4'd9, 5);
        // R7: same stretch case again after reset restarts the pattern
        run_case("R7", 2'b01, 8'd0, 8'd3, 4'd2, 4'd5, 7);
        run_case("R7", 2'b01, 8'd0, 8'd3, 4'd2, 4'd5, 7);
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        total++;
        bad++;
        $display("FAIL watchdog: run hung actual=timeout expected=done");
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule